// File: doc/BRIEF.md
# Floating-Point Condition Code Unit

This block keeps the four condition flags that describe the most recent floating-point result. The flags are negative, zero, infinity and not-a-number. Each cycle, the block takes at most one update request. An arithmetic request sends the class and sign of a result, and the block turns them into a flag pattern. A compare request sends the class and sign of the operand difference together with an unordered indication. A software load writes any of the sixteen patterns as it stands. With no request, the flags hold their value.

Beside the register there is a combinational evaluator. It takes a five-bit predicate selector and answers whether the held flags satisfy it. The low four selector bits choose a set of relations, and the predicate is true when any chosen relation holds. The top bit marks the signaling group. A signaling predicate evaluated while the not-a-number flag is set raises an unordered-error output. A branch or set-on-condition stage drives the selector.

Top module: `fpcc_unit`

## Requirements
- R1: In the cycle after reset is asserted, `cc` is 0000. The bit order of `cc` is {N, Z, I, NAN}, with N at bit 3.
- R2: An arithmetic request (`op_kind`=1) with class 0, meaning finite nonzero, loads N=`val_sign` and Z=I=NAN=0 on the next edge.
- R3: An arithmetic request with class 1, meaning zero, loads 0100 for plus and 1100 for minus.
- R4: An arithmetic request with class 2, meaning infinity, loads 0010 for plus and 1010 for minus.
- R5: An arithmetic request with class 3, meaning NaN, loads 0001 for plus and 1001 for minus, so every NaN result sets NAN.
- R6: A compare request (`op_kind`=2) with `cmp_unord`=0 classifies the difference exactly as R2 to R5 do. With `cmp_unord`=1 it loads 0001, whatever the class and sign inputs are.
- R7: With `op_kind`=0, `cc` keeps its value, whatever the other inputs are.
- R8: A load request (`op_kind`=3) writes `load_code` into `cc` unchanged, for all 16 patterns.
- R9: Four relations are derived from `cc`:
  - eq = Z & ~NAN
  - gt = ~(NAN | Z | N)
  - lt = N & ~(NAN | Z)
  - un = NAN

  `pred_sel[0]`, `pred_sel[1]`, `pred_sel[2]` and `pred_sel[3]` select eq, gt, lt and un. `pred_true` is the OR of the selected relations, so mask 0 is always false and mask 15 is always true.
- R10: `pred_unord_err` is 1 exactly when `pred_sel[4]`=1 and NAN=1. It stays 0 whenever `pred_sel[4]`=0.
- R11: Arithmetic and compare requests only ever produce patterns in which at most one of Z, I and NAN is set. That gives eight possible patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Update request: 0 none, 1 arithmetic, 2 compare, 3 software load |
| val_sign | input | 1 | Sign of the result or of the difference |
| val_class | input | 2 | Class of the value: 0 finite nonzero, 1 zero, 2 infinity, 3 NaN |
| cmp_unord | input | 1 | A compare operand was NaN |
| load_code | input | 4 | Pattern for a software load |
| pred_sel | input | 5 | Predicate selector: bit 4 signaling group, bits 3:0 relation mask |
| cc | output | 4 | Held flags {N, Z, I, NAN} |
| pred_true | output | 1 | Predicate result for the held flags |
| pred_unord_err | output | 1 | Signaling predicate evaluated while unordered |

## Verification
Arithmetic requests cover all four classes with both signs. This separates the sign path from the class path and shows that the NaN sign is kept. Compare requests are sent with the unordered flag clear and set on the same class inputs, which shows that the unordered override outranks the difference class. All sixteen loaded patterns are swept against all 32 selectors. The illegal patterns this covers, such as Z together with NAN, show that the relations are evaluated literally and that the error output follows only the signaling bit and NAN.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int CC_W   = 4;
    localparam int SEL_W  = 5;
    localparam int MASK_W = SEL_W - 1;
    localparam int SIG_BIT = SEL_W - 1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ARITH = 2'd1,
        OP_CMP   = 2'd2,
        OP_LOAD  = 2'd3
    } cc_op_e;

    typedef enum logic [1:0] {
        VC_FINITE = 2'd0,
        VC_ZERO   = 2'd1,
        VC_INF    = 2'd2,
        VC_NAN    = 2'd3
    } val_class_e;

    // Flag word, N in the most significant position
    typedef struct packed {
        logic n;
        logic z;
        logic i;
        logic nan;
    } cc_t;

    // Relation vector, eq in bit 0 so it lines up with the selector mask
    typedef struct packed {
        logic un;
        logic lt;
        logic gt;
        logic eq;
    } rel_t;

    function automatic cc_t classify(input logic sign, input val_class_e cls);
        cc_t r;
        r     = '0;
        r.n   = sign;
        r.z   = (cls == VC_ZERO);
        r.i   = (cls == VC_INF);
        r.nan = (cls == VC_NAN);
        return r;
    endfunction

    function automatic rel_t relations(input cc_t c);
        rel_t r;
        r.eq = c.z & ~c.nan;
        r.gt = ~(c.nan | c.z | c.n);
        r.lt = c.n & ~(c.nan | c.z);
        r.un = c.nan;
        return r;
    endfunction

endpackage

// File: rtl/fpcc_next.sv
module fpcc_next
    import fpcc_pkg::*;
(
    input  cc_op_e           op,
    input  logic             sign,
    input  val_class_e       cls,
    input  logic             unord,
    input  logic [CC_W-1:0]  load_code,
    output logic             we,
    output cc_t              next_cc
);
    cc_t unord_code;

    always_comb begin
        unord_code     = '0;
        unord_code.nan = 1'b1;
    end

    always_comb begin
        we      = 1'b0;
        next_cc = '0;
        unique case (op)
            OP_ARITH: begin
                we      = 1'b1;
                next_cc = classify(sign, cls);
            end
            OP_CMP: begin
                we      = 1'b1;
                next_cc = unord ? unord_code : classify(sign, cls);
            end
            OP_LOAD: begin
                we      = 1'b1;
                next_cc = cc_t'(load_code);
            end
            default: begin
                we      = 1'b0;
                next_cc = '0;
            end
        endcase
    end
endmodule

// File: rtl/fpcc_reg.sv
module fpcc_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/fpcc_pred.sv
module fpcc_pred
    import fpcc_pkg::*;
(
    input  cc_t               cc,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit,
    output logic              unord_err
);
    rel_t              rel;
    logic [MASK_W-1:0] rel_vec;
    logic [MASK_W-1:0] picked;

    assign rel     = relations(cc);
    assign rel_vec = rel;

    for (genvar g = 0; g < MASK_W; g++) begin : g_pick
        assign picked[g] = sel[g] & rel_vec[g];
    end

    assign hit       = |picked;
    assign unord_err = sel[SIG_BIT] & cc.nan;
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_kind,
    input  logic              val_sign,
    input  logic [1:0]        val_class,
    input  logic              cmp_unord,
    input  logic [CC_W-1:0]   load_code,
    input  logic [SEL_W-1:0]  pred_sel,
    output logic [CC_W-1:0]   cc,
    output logic              pred_true,
    output logic              pred_unord_err
);
    logic            we;
    cc_t             next_cc;
    logic [CC_W-1:0] held;

    fpcc_next u_next (
        .op        (cc_op_e'(op_kind)),
        .sign      (val_sign),
        .cls       (val_class_e'(val_class)),
        .unord     (cmp_unord),
        .load_code (load_code),
        .we        (we),
        .next_cc   (next_cc)
    );

    fpcc_reg #(.W(CC_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .we  (we),
        .d   (next_cc),
        .q   (held)
    );

    fpcc_pred u_pred (
        .cc        (cc_t'(held)),
        .sel       (pred_sel),
        .hit       (pred_true),
        .unord_err (pred_unord_err)
    );

    assign cc = held;
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk
    import fpcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op_kind,
    input logic              val_sign,
    input logic [1:0]        val_class,
    input logic              cmp_unord,
    input logic [CC_W-1:0]   load_code,
    input logic [SEL_W-1:0]  pred_sel,
    input logic [CC_W-1:0]   cc,
    input logic              pred_true,
    input logic              pred_unord_err
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> cc == '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_kind == 2'd0 |=> $stable(cc));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        op_kind == 2'd3 |=> cc == $past(load_code));

    // R5
    nan_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd1 && val_class == 2'd3) |=> cc[0] && cc[3] == $past(val_sign));

    // R6
    unord_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd2 && cmp_unord) |=> cc == 4'b0001);

    // R11
    legal_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd1 || op_kind == 2'd2) |=> $countones(cc[2:0]) <= 1);

    // R10
    quiet_group_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_sel[SIG_BIT] |-> !pred_unord_err);

    // R10
    signal_group_chk: assert property (@(posedge clk) disable iff (rst)
        (pred_sel[SIG_BIT] && cc[0]) |-> pred_unord_err);

    // R9
    mask_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pred_sel[MASK_W-1:0] == '0 |-> !pred_true);

    // R9
    mask_full_chk: assert property (@(posedge clk) disable iff (rst)
        pred_sel[MASK_W-1:0] == '1 |-> pred_true);
endmodule

bind fpcc_unit fpcc_unit_chk u_chk (.*);

// File: tb/tb_fpcc_unit.sv
`timescale 1ns/1ps
module tb_fpcc_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] op_kind;
    logic       val_sign;
    logic [1:0] val_class;
    logic       cmp_unord;
    logic [3:0] load_code;
    logic [4:0] pred_sel;
    logic [3:0] cc;
    logic       pred_true;
    logic       pred_unord_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpcc_unit dut (.*);

    task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_class(input logic s, input logic [1:0] c);
        case (c)
            2'd0:    return {s, 3'b000};
            2'd1:    return {s, 3'b100};
            2'd2:    return {s, 3'b010};
            default: return {s, 3'b001};
        endcase
    endfunction

    function automatic logic expect_pred(input logic [3:0] c, input logic [4:0] s);
        logic n, z, nan, eq, gt, lt, un;
        n = c[3]; z = c[2]; nan = c[0];
        eq = z & ~nan;
        gt = ~(nan | z | n);
        lt = n & ~(nan | z);
        un = nan;
        return (s[0] & eq) | (s[1] & gt) | (s[2] & lt) | (s[3] & un);
    endfunction

    task automatic issue(input logic [1:0] op, input logic s, input logic [1:0] c,
                         input logic u, input logic [3:0] ld);
        @(negedge clk);
        op_kind = op; val_sign = s; val_class = c; cmp_unord = u; load_code = ld;
        @(negedge clk);
        op_kind = 2'd0;
    endtask

    task automatic t_reset();
        issue(2'd3, 1'b0, 2'd0, 1'b0, 4'b1111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk4("R1 reset", cc, 4'b0000);
    endtask

    task automatic t_arith();
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                issue(2'd1, s[0], c[1:0], 1'b0, 4'b0110);
                case (c)
                    0: chk4("R2 arith finite", cc, expect_class(s[0], c[1:0]));
                    1: chk4("R3 arith zero", cc, expect_class(s[0], c[1:0]));
                    2: chk4("R4 arith inf", cc, expect_class(s[0], c[1:0]));
                    default: chk4("R5 arith nan", cc, expect_class(s[0], c[1:0]));
                endcase
                chk1("R11 at most one of Z I NAN", ($countones(cc[2:0]) <= 1), 1'b1);
            end
        end
    endtask

    task automatic t_compare();
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                issue(2'd2, s[0], c[1:0], 1'b0, 4'b1111);
                chk4("R6 compare ordered", cc, expect_class(s[0], c[1:0]));
                issue(2'd2, s[0], c[1:0], 1'b1, 4'b1111);
                chk4("R6 compare unordered", cc, 4'b0001);
                chk1("R11 compare pattern", ($countones(cc[2:0]) <= 1), 1'b1);
            end
        end
    endtask

    task automatic t_hold();
        issue(2'd1, 1'b1, 2'd2, 1'b0, 4'b0000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_kind = 2'd0; val_sign = k[0]; val_class = k[1:0];
            cmp_unord = k[1]; load_code = 4'(k * 5);
            @(negedge clk);
            chk4("R7 idle holds", cc, 4'b1010);
        end
    endtask

    task automatic t_load_and_pred();
        for (int p = 0; p < 16; p++) begin
            issue(2'd3, 1'b0, 2'd0, 1'b0, 4'(p));
            chk4("R8 load", cc, 4'(p));
            for (int s = 0; s < 32; s++) begin
                pred_sel = 5'(s);
                #0.5;
                chk1("R9 predicate", pred_true, expect_pred(4'(p), 5'(s)));
                chk1("R10 unordered error", pred_unord_err, s[4] & p[0]);
            end
            pred_sel = 5'd0;
        end
    endtask

    initial begin
        rst = 1'b1; op_kind = 2'd0; val_sign = 1'b0; val_class = 2'd0;
        cmp_unord = 1'b0; load_code = 4'd0; pred_sel = 5'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk4("R1 after reset", cc, 4'b0000);
        t_arith();
        t_compare();
        t_hold();
        t_load_and_pred();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule